// File: doc/BRIEF.md
# Command-Byte Gated Serial Register Slave

This block is the device end of a three-wire serial link to a converter's register set. Every access begins with a one-byte command shifted into the communications register. The command picks a target register, a direction and an input channel. The bits that follow in the same chip-select window then form the selected transfer. When that transfer is done, the block waits for a new command byte. No address phase exists inside a data transfer: the length and direction of each transfer come from the command before it.

The register file holds an 8-bit mode register, two 8-bit filter registers and a 24-bit read-only conversion result. The conversion engine loads the result through an update strobe. A ready pin, active low, reports that a fresh result is waiting. The same state can be read as the top bit of the communications register. The serial clock is oversampled by the system clock. A polarity input picks the clock's idle level, so hosts that idle low and hosts that idle high are both supported. Chip select may be driven per frame or tied low.

Top module: `ssi_cmd_slave`

## Requirements
- R1: After reset, rdy_no is high, sdo_o is low, cal_start_o is low, and chan_o, mode_o, filt_hi_o and filt_lo_o are all zero.
- R2: A command byte is shifted in MSB first. Bits 6:4 select the register: 000 communications, 001 mode, 010 filter high, 011 filter low, 101 data. Bit 3 is 1 for read and 0 for write. Bits 2:0 set the channel, which appears on chan_o. Bit 7 of a written command is ignored.
- R3: A command byte followed by 8 data bits in one continuous 16-clock frame writes the data to the selected 8-bit register.
- R4: A read of the mode or filter registers returns the 8-bit value on sdo_o, MSB first, over 8 clocks.
- R5: A data-register read lasts 24 clocks and returns the word, MSB first. The word is the one latched at the start of the read. Splitting the 24 clocks into three groups of 8, with idle time between groups, gives the same word.
- R6: An update strobe loads upd_data_i and drives rdy_no low. A communications-register read returns rdy_no in bit 7 and the command's bits 6:0 in bits 6:0.
- R7: rdy_no returns high once all 24 bits of a data read have been shifted, and stays high until the next update. If an update arrives during a data read, the word being shifted is unchanged and rdy_no stays low afterwards.
- R8: sdo_o stays low during command and write phases. sdi_i is ignored during a read phase.
- R9: With pol_i high, the serial clock idles high and transfers behave as they do with pol_i low.
- R10: Chip select going high in mid-frame drops the partial transfer with no register change. The next frame starts with a command byte.
- R11: Writes to the data register or to unassigned selections are consumed (24 clocks for data, 8 otherwise) and discarded.
- R12: A mode write with bits 7:5 not 000 gives a single-cycle cal_start_o pulse and forces rdy_no high until the next update.
- R13: A command that writes the communications register (select 000, write) opens no data phase. The next 8 clocks are taken as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial link |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in |
| pol_i | input | 1 | Serial clock idle level: 0 idles low, 1 idles high |
| upd_i | input | 1 | Result update strobe from the conversion engine |
| upd_data_i | input | 24 | New conversion result |
| sdo_o | output | 1 | Serial data out |
| rdy_no | output | 1 | Result ready, active low |
| cal_start_o | output | 1 | Single-cycle calibration start pulse |
| chan_o | output | 3 | Channel from the last command |
| mode_o | output | 8 | Mode register |
| filt_hi_o | output | 8 | Filter high register |
| filt_lo_o | output | 8 | Filter low register |

## Verification
A corrupted bit counter or phase state mostly shows up one frame late. The next command is decoded from shifted bits, so a control register changes that should not, or a read returns a value off by a shift. Each write is therefore followed by a check of the register outputs, and each read is scored bit for bit. Errors in ready tracking appear at rdy_no within a few system clocks of an update, a completed data read or a calibration write. Those points are sampled right after each such event, and the pin is also checked against bit 7 of a communications read.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  localparam logic [2:0] SEL_COMM = 3'b000;
  localparam logic [2:0] SEL_MODE = 3'b001;
  localparam logic [2:0] SEL_FHI  = 3'b010;
  localparam logic [2:0] SEL_FLO  = 3'b011;
  localparam logic [2:0] SEL_DATA = 3'b101;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_LD, PH_RD} phase_e;

  // command byte without its ready bit (bit 7)
  typedef struct packed {
    logic [2:0] sel;
    logic       rd;
    logic [2:0] chan;
  } cmd_t;
endpackage

// File: rtl/ssi_sync.sv
module ssi_sync #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic sdi_i,
  input  logic pol_i,
  output logic lead_o,
  output logic cs_act_o,
  output logic sdi_o
);
  logic [SYNC:0]   clk_sh_q;
  logic [SYNC-1:0] cs_sh_q;
  logic [SYNC-1:0] sdi_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sh_q <= '0;
      cs_sh_q  <= '1;
      sdi_sh_q <= '0;
    end else begin
      // polarity folded in so the leading edge is always a rise
      clk_sh_q <= {clk_sh_q[SYNC-1:0], sclk_i ^ pol_i};
      cs_sh_q  <= {cs_sh_q[SYNC-2:0], cs_ni};
      sdi_sh_q <= {sdi_sh_q[SYNC-2:0], sdi_i};
    end
  end

  assign lead_o   = clk_sh_q[SYNC-1] & ~clk_sh_q[SYNC];
  assign cs_act_o = ~cs_sh_q[SYNC-1];
  assign sdi_o    = sdi_sh_q[SYNC-1];
endmodule

// File: rtl/ssi_frame.sv
module ssi_frame
  import ssi_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CTRL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lead_i,
  input  logic              cs_act_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic              sdo_o,
  output cmd_t              cmd_o,
  output logic              wr_stb_o,
  output logic [CTRL_W-1:0] wr_data_o,
  output logic              rd_start_o,
  output logic              rd_done_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CTRL_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  cmd_t              cmd_q;
  logic              cmd_stb_q, wr_stb_q, rd_start_q, rd_done_q;

  logic [DATA_W-1:0] shin;
  cmd_t              nc;
  phase_e            nc_phase;
  logic [CNT_W-1:0]  last;

  assign shin = {sh_q[DATA_W-2:0], sdi_i};
  assign nc   = cmd_t'(shin[CTRL_W-2:0]);
  assign last = (cmd_q.sel == SEL_DATA) ? LAST_D : LAST_C;

  always_comb begin
    if (nc.rd)                  nc_phase = PH_LD;
    else if (nc.sel == SEL_COMM) nc_phase = PH_CMD;
    else                        nc_phase = PH_WR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_CMD;
      cnt_q      <= '0;
      sh_q       <= '0;
      cmd_q      <= '0;
      cmd_stb_q  <= 1'b0;
      wr_stb_q   <= 1'b0;
      rd_start_q <= 1'b0;
      rd_done_q  <= 1'b0;
    end else begin
      cmd_stb_q  <= 1'b0;
      wr_stb_q   <= 1'b0;
      rd_start_q <= 1'b0;
      rd_done_q  <= 1'b0;
      if (!cs_act_i) begin
        phase_q <= PH_CMD;
        cnt_q   <= '0;
      end else if (phase_q == PH_LD) begin
        sh_q       <= rd_word_i;
        phase_q    <= PH_RD;
        rd_start_q <= 1'b1;
      end else if (lead_i) begin
        unique case (phase_q)
          PH_CMD: begin
            sh_q <= shin;
            if (cnt_q == LAST_C) begin
              cmd_q     <= nc;
              cmd_stb_q <= 1'b1;
              cnt_q     <= '0;
              phase_q   <= nc_phase;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          PH_WR: begin
            sh_q <= shin;
            if (cnt_q == last) begin
              wr_stb_q <= 1'b1;
              cnt_q    <= '0;
              phase_q  <= PH_CMD;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          PH_RD: begin
            // sdi is not sampled while reading
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
            if (cnt_q == last) begin
              rd_done_q <= 1'b1;
              cnt_q     <= '0;
              phase_q   <= PH_CMD;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo_o      = (phase_q == PH_RD) & sh_q[DATA_W-1];
  assign cmd_o      = cmd_q;
  assign wr_stb_o   = wr_stb_q;
  assign wr_data_o  = sh_q[CTRL_W-1:0];
  assign rd_start_o = rd_start_q;
  assign rd_done_o  = rd_done_q;

  a_r10_cs_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (phase_q == PH_CMD && cnt_q == '0));
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_D);
  a_r13_comm_write_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_q && cmd_q.sel == SEL_COMM && !cmd_q.rd) |-> phase_q == PH_CMD);
  a_r8_read_follows_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_q |-> phase_q == PH_RD);
endmodule

// File: rtl/ssi_regs.sv
module ssi_regs
  import ssi_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CTRL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_t              cmd_i,
  input  logic              wr_stb_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              rd_start_i,
  input  logic              rd_done_i,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] upd_data_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic              rdy_n_o,
  output logic              cal_o,
  output logic [CTRL_W-1:0] mode_o,
  output logic [CTRL_W-1:0] fhi_o,
  output logic [CTRL_W-1:0] flo_o
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic [CTRL_W-1:0] mode_q, fhi_q, flo_q;
  logic [DATA_W-1:0] data_q;
  logic              rdy_n_q, fresh_q, cal_q;
  logic              cal_wr, data_sel;

  assign data_sel = (cmd_i.sel == SEL_DATA);
  assign cal_wr   = wr_stb_i && (cmd_i.sel == SEL_MODE) &&
                    (wr_data_i[CTRL_W-1:CTRL_W-3] != 3'b000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      fhi_q  <= '0;
      flo_q  <= '0;
    end else if (wr_stb_i) begin
      unique case (cmd_i.sel)
        SEL_MODE: mode_q <= wr_data_i;
        SEL_FHI:  fhi_q  <= wr_data_i;
        SEL_FLO:  flo_q  <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else if (upd_i) data_q <= upd_data_i;
  end

  // fresh: no update since this data read latched its word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_n_q <= 1'b1;
      fresh_q <= 1'b0;
      cal_q   <= 1'b0;
    end else begin
      cal_q <= cal_wr;
      if (upd_i)                        fresh_q <= 1'b0;
      else if (rd_start_i && data_sel)  fresh_q <= 1'b1;
      if (cal_wr)                                rdy_n_q <= 1'b1;
      else if (upd_i)                            rdy_n_q <= 1'b0;
      else if (rd_done_i && data_sel && fresh_q) rdy_n_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (cmd_i.sel)
      SEL_COMM: rd_word_o = {rdy_n_q, cmd_i, {PAD_W{1'b0}}};
      SEL_MODE: rd_word_o = {mode_q, {PAD_W{1'b0}}};
      SEL_FHI:  rd_word_o = {fhi_q, {PAD_W{1'b0}}};
      SEL_FLO:  rd_word_o = {flo_q, {PAD_W{1'b0}}};
      SEL_DATA: rd_word_o = data_q;
      default:  rd_word_o = '0;
    endcase
  end

  assign rdy_n_o = rdy_n_q;
  assign cal_o   = cal_q;
  assign mode_o  = mode_q;
  assign fhi_o   = fhi_q;
  assign flo_o   = flo_q;

  a_r12_cal_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_q |=> !cal_q);
  a_r12_cal_rdy_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_q |-> rdy_n_q);
  a_r6_upd_lowers_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !cal_wr) |=> !rdy_n_q);
  a_r7_rdy_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_n_q) |-> $past(rd_done_i || cal_wr));
  a_r11_data_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(data_q));
endmodule

// File: rtl/ssi_cmd_slave.sv
module ssi_cmd_slave
  import ssi_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CTRL_W = 8,
  parameter int SYNC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  input  logic              pol_i,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] upd_data_i,
  output logic              sdo_o,
  output logic              rdy_no,
  output logic              cal_start_o,
  output logic [2:0]        chan_o,
  output logic [CTRL_W-1:0] mode_o,
  output logic [CTRL_W-1:0] filt_hi_o,
  output logic [CTRL_W-1:0] filt_lo_o
);
  logic              lead, cs_act, sdi_s;
  logic [DATA_W-1:0] rd_word;
  cmd_t              cmd;
  logic              wr_stb, rd_start, rd_done;
  logic [CTRL_W-1:0] wr_data;

  ssi_sync #(.SYNC(SYNC)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (sclk_i),
    .cs_ni    (cs_ni),
    .sdi_i    (sdi_i),
    .pol_i    (pol_i),
    .lead_o   (lead),
    .cs_act_o (cs_act),
    .sdi_o    (sdi_s)
  );

  ssi_frame #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lead_i     (lead),
    .cs_act_i   (cs_act),
    .sdi_i      (sdi_s),
    .rd_word_i  (rd_word),
    .sdo_o      (sdo_o),
    .cmd_o      (cmd),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .rd_start_o (rd_start),
    .rd_done_o  (rd_done)
  );

  ssi_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .wr_stb_i   (wr_stb),
    .wr_data_i  (wr_data),
    .rd_start_i (rd_start),
    .rd_done_i  (rd_done),
    .upd_i      (upd_i),
    .upd_data_i (upd_data_i),
    .rd_word_o  (rd_word),
    .rdy_n_o    (rdy_no),
    .cal_o      (cal_start_o),
    .mode_o     (mode_o),
    .fhi_o      (filt_hi_o),
    .flo_o      (filt_lo_o)
  );

  assign chan_o = cmd.chan;
endmodule

// File: tb/ssi_cmd_slave_tb_top.sv
module ssi_cmd_slave_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, pol = 1'b0, upd = 1'b0;
  logic [23:0] upd_data = '0;
  logic sdo, rdy_n, cal;
  logic [2:0] chan;
  logic [7:0] mode, fhi, flo;

  int n_chk = 0, n_fail = 0, cal_cnt = 0;
  bit quiet_bad = 1'b0, done = 1'b0;
  logic [2:0] cur_chan = 3'd6;

  logic [23:0] exp_q[$];
  logic [23:0] act_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ssi_cmd_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .pol_i(pol), .upd_i(upd), .upd_data_i(upd_data), .sdo_o(sdo),
    .rdy_no(rdy_n), .cal_start_o(cal), .chan_o(chan), .mode_o(mode),
    .filt_hi_o(fhi), .filt_lo_o(flo)
  );

  always @(negedge clk) if (cal) cal_cnt++;

  // monitor: scores read results against driver expectations
  always @(negedge clk) begin
    if (act_q.size() != 0) begin
      logic [23:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: read actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic check(input string t, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, a, e);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] cmdb(input logic [2:0] sel, input logic rd);
    return {1'b0, sel, rd, cur_chan};
  endfunction

  task automatic shift(input int n, input logic [23:0] wv, input bit rd,
                       output logic [23:0] rv);
    rv = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = rd ? 1'b1 : wv[i];
      waitc(HALF);
      if (rd) rv[i] = sdo;
      else if (sdo) quiet_bad = 1'b1;
      sclk = ~pol;
      waitc(HALF);
      sclk = pol;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; waitc(4);
  endtask

  task automatic cs_hi();
    waitc(4); cs_n = 1'b1; waitc(8);
  endtask

  task automatic wr_frame(input logic [2:0] sel, input logic [23:0] v, input int n);
    logic [23:0] d;
    cs_lo();
    shift(8, {16'h0, cmdb(sel, 1'b0)}, 1'b0, d);
    shift(n, v, 1'b0, d);
    cs_hi();
  endtask

  task automatic rd_frame(input logic [2:0] sel, input int n, input logic [23:0] e,
                          input string t);
    logic [23:0] d, r;
    exp_q.push_back(e);
    tag_q.push_back(t);
    cs_lo();
    shift(8, {16'h0, cmdb(sel, 1'b1)}, 1'b0, d);
    shift(n, 24'h0, 1'b1, r);
    cs_hi();
    act_q.push_back(r);
  endtask

  task automatic pulse_upd(input logic [23:0] v);
    @(negedge clk); upd = 1'b1; upd_data = v;
    @(negedge clk); upd = 1'b0;
    waitc(2);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic [23:0] d, r;
    waitc(5);
    rst_n = 1'b1;
    waitc(3);
    // R1 reset state
    check("R1 rdy", {31'h0, rdy_n}, 32'h1);
    check("R1 sdo", {31'h0, sdo}, 32'h0);
    check("R1 regs", {5'h0, chan, mode, fhi, flo}, 32'h0);
    check("R1 cal", {31'h0, cal}, 32'h0);

    // R2 R3 single 16-clock frames
    wr_frame(3'b010, 24'h4F, 8);
    check("R3 filt_hi", {24'h0, fhi}, 32'h4F);
    check("R2 chan", {29'h0, chan}, 32'h6);
    wr_frame(3'b011, 24'hA0, 8);
    wr_frame(3'b001, 24'h07, 8);
    check("R3 filt_lo", {24'h0, flo}, 32'hA0);
    check("R3 mode", {24'h0, mode}, 32'h07);
    check("R12 no cal on plain mode write", cal_cnt, 0);

    // R4 readback
    rd_frame(3'b001, 8, 24'h07, "R4 mode");
    rd_frame(3'b010, 8, 24'h4F, "R4 filt_hi");
    rd_frame(3'b011, 8, 24'hA0, "R4 filt_lo");

    // R13 comms write then command in same frame; R2 ignores bit 7
    cur_chan = 3'd3;
    cs_lo();
    shift(8, {16'h0, 8'h80 | cmdb(3'b000, 1'b0)}, 1'b0, d);
    shift(8, {16'h0, cmdb(3'b011, 1'b0)}, 1'b0, d);
    shift(8, 24'h5A, 1'b0, d);
    cs_hi();
    check("R13 filt_lo", {24'h0, flo}, 32'h5A);
    check("R2 chan update", {29'h0, chan}, 32'h3);

    // R6 ready and comms readback
    pulse_upd(24'hABCDEF);
    check("R6 rdy low", {31'h0, rdy_n}, 32'h0);
    rd_frame(3'b000, 8, 24'h0B, "R6 comms bit7 low");

    // R5 R7 24-clock read
    rd_frame(3'b101, 24, 24'hABCDEF, "R5 data 24");
    check("R7 rdy high after read", {31'h0, rdy_n}, 32'h1);
    rd_frame(3'b000, 8, 24'h8B, "R6 comms bit7 high");
    waitc(40);
    check("R7 rdy stays high", {31'h0, rdy_n}, 32'h1);

    // R5 split read into three byte groups
    pulse_upd(24'h123456);
    exp_q.push_back(24'h123456);
    tag_q.push_back("R5 data split");
    cs_lo();
    shift(8, {16'h0, cmdb(3'b101, 1'b1)}, 1'b0, d);
    shift(8, 24'h0, 1'b1, r);
    d[23:16] = r[7:0];
    waitc(60);
    shift(8, 24'h0, 1'b1, r);
    d[15:8] = r[7:0];
    waitc(60);
    check("R7 rdy low mid-read", {31'h0, rdy_n}, 32'h0);
    shift(8, 24'h0, 1'b1, r);
    d[7:0] = r[7:0];
    cs_hi();
    act_q.push_back(d);
    check("R7 rdy high after split read", {31'h0, rdy_n}, 32'h1);

    // R7 update during read
    pulse_upd(24'h111111);
    exp_q.push_back(24'h111111);
    tag_q.push_back("R7 word held during update");
    cs_lo();
    shift(8, {16'h0, cmdb(3'b101, 1'b1)}, 1'b0, d);
    shift(8, 24'h0, 1'b1, r);
    d[23:16] = r[7:0];
    pulse_upd(24'h222222);
    shift(16, 24'h0, 1'b1, r);
    d[15:0] = r[15:0];
    cs_hi();
    act_q.push_back(d);
    check("R7 rdy low after stale read", {31'h0, rdy_n}, 32'h0);
    rd_frame(3'b101, 24, 24'h222222, "R7 new word");
    check("R7 rdy high after new read", {31'h0, rdy_n}, 32'h1);

    // R8 sdi ignored in read (bench drives ones), then registers intact
    rd_frame(3'b010, 8, 24'h4F, "R8 read with sdi high");
    check("R8 regs unchanged", {8'h0, mode, fhi, flo}, 32'h074F5A);
    wr_frame(3'b001, 24'h05, 8);
    check("R8 next command decoded", {24'h0, mode}, 32'h05);

    // R10 abort mid-write
    cs_lo();
    shift(8, {16'h0, cmdb(3'b010, 1'b0)}, 1'b0, d);
    shift(5, 24'h1F, 1'b0, d);
    cs_hi();
    check("R10 partial write dropped", {24'h0, fhi}, 32'h4F);
    wr_frame(3'b010, 24'h99, 8);
    check("R10 next frame ok", {24'h0, fhi}, 32'h99);

    // R11 writes to data and unused selections discarded
    pulse_upd(24'h333333);
    wr_frame(3'b101, 24'hFFFFFF, 24);
    wr_frame(3'b110, 24'hFF, 8);
    check("R11 regs intact", {8'h0, mode, fhi, flo}, 32'h05995A);
    rd_frame(3'b101, 24, 24'h333333, "R11 data unchanged");

    // R12 calibration
    pulse_upd(24'h444444);
    check("R12 rdy low before cal", {31'h0, rdy_n}, 32'h0);
    wr_frame(3'b001, 24'h20, 8);
    check("R12 one cal pulse", cal_cnt, 1);
    check("R12 rdy high after cal", {31'h0, rdy_n}, 32'h1);
    pulse_upd(24'h555555);
    check("R12 rdy low after update", {31'h0, rdy_n}, 32'h0);

    // R9 idle-high clock
    pol = 1'b1; sclk = 1'b1;
    waitc(8);
    wr_frame(3'b011, 24'hC3, 8);
    check("R9 write pol high", {24'h0, flo}, 32'hC3);
    rd_frame(3'b011, 8, 24'hC3, "R9 read pol high");
    rd_frame(3'b101, 24, 24'h555555, "R9 data pol high");

    // R8 quiet output in command and write phases
    check("R8 sdo quiet", {31'h0, quiet_bad}, 32'h0);

    waitc(20);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule